// File: doc/BRIEF.md
# Serial DAC Command Slave

This block is the digital control side of a single-channel 10-bit voltage DAC. A host talks to it over a three-wire serial port with an active-low select, a serial clock and a data line. Each 16-bit frame is decoded as a command. The command either loads a new DAC code, or changes the power state and the output termination. The block keeps the code register and the power state. It drives the code into the converter, a power-down flag, and a 2-bit termination select for the analog output stage.

All three serial pins are oversampled by a free-running system clock. That clock must run at least four times faster than the serial clock. Each pin passes through a two-flop synchroniser, and its edges are found in the system clock domain. A frame begins on a falling select edge and shifts in one bit on each falling serial clock edge, most significant bit first. The command takes effect the moment the sixteenth bit arrives, whether the select line then stays low or goes high.

After reset the converter is powered down with its output tied to ground through 100k. A wake-up command must come first. The stored code survives power-down, so waking up restores the previous output.

Top module: `dac_cmd_slave`

## Requirements
- R1: After reset `dac_code` is 0, `pwr_dn` is 1 and `term_sel` is 2'b11 (100k to ground).
- R2: A frame bit is sampled on each falling edge of `sclk` while `cs_n` is low, MSB first. Word bits [15:12] are the command, bits [11:2] are the code, and bits [1:0] are the mode select.
- R3: Command 4'b0000, received while `pwr_dn` is 0, writes bits [11:2] to `dac_code`.
- R4: Command 4'b1111 with select 2'b00 clears `pwr_dn` and sets `term_sel` to 2'b00. `dac_code` returns to the value it held before power-down.
- R5: Command 4'b1111 with a non-zero select sets `pwr_dn` and copies the select to `term_sel`: 2'b01 floating, 2'b10 1k to ground, 2'b11 100k to ground.
- R6: Command 4'b0000 received while `pwr_dn` is 1 leaves `dac_code` unchanged.
- R7: If `cs_n` rises before the sixteenth falling `sclk` edge of a frame, the frame has no effect on any output.
- R8: A frame takes effect on its sixteenth falling edge while `cs_n` is still low. Further falling edges before `cs_n` rises change nothing.
- R9: Command nibbles other than 4'b0000 and 4'b1111 leave all outputs unchanged.
- R10: Frames decode the same whether `sclk` idles high or low.
- R11: Outputs change only in the cycle after the sixteenth falling `sclk` edge of an active frame is detected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System oversampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial select, active low |
| sclk | input | 1 | Serial clock |
| sdi | input | 1 | Serial data in |
| dac_code | output | 10 | Code applied to the converter |
| pwr_dn | output | 1 | Converter powered down |
| term_sel | output | 2 | Output termination: 00 driven, 01 floating, 10 1k, 11 100k |

## Verification
A rise of the select line can land in the same system cycle as the detection of a frame's final clock edge. The bench provokes this by moving `cs_n` high in the same time step as the last falling `sclk` edge. Both pins then reach the edge detectors through equal synchroniser depth. When the coincident edge is the sixteenth, the command is expected to take effect. When it is the fifteenth, the frame is expected to be discarded. The outputs are compared against a bench model after each case.

// File: rtl/dac_cmd_slave.sv
module dac_cmd_slave #(
  parameter int CODE_W  = 10,
  parameter int CMD_W   = 4,
  parameter int SEL_W   = 2,
  parameter int FRAME_W = CMD_W + CODE_W + SEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              sdi,
  output logic [CODE_W-1:0] dac_code,
  output logic              pwr_dn,
  output logic [SEL_W-1:0]  term_sel
);
  localparam int CNT_W = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_W);

  logic [2:0] cs_q, sck_q;
  logic [1:0] sdi_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cs_q  <= '1;
      sck_q <= '0;
      sdi_q <= '0;
    end else begin
      cs_q  <= {cs_q[1:0], cs_n};
      sck_q <= {sck_q[1:0], sclk};
      sdi_q <= {sdi_q[0], sdi};
    end

  wire cs_fall  = cs_q[2] & ~cs_q[1];
  wire cs_high  = cs_q[1];
  wire sck_fall = sck_q[2] & ~sck_q[1];
  wire bit_in   = sdi_q[1];

  logic               active;
  logic [CNT_W-1:0]   cnt;
  logic [FRAME_W-2:0] shreg;

  wire                shift = active && sck_fall && (cnt < FULL);
  wire                take  = active && sck_fall && (cnt == LAST);
  wire [FRAME_W-1:0]  word  = {shreg, bit_in};
  wire [CMD_W-1:0]    cmd   = word[FRAME_W-1 -: CMD_W];
  wire [CODE_W-1:0]   data  = word[SEL_W +: CODE_W];
  wire [SEL_W-1:0]    sel   = word[SEL_W-1:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
      shreg  <= '0;
    end else begin
      if (shift) begin
        shreg <= {shreg[FRAME_W-3:0], bit_in};
        cnt   <= cnt + 1'b1;
      end
      if (cs_high)
        active <= 1'b0;
      else if (cs_fall) begin
        active <= 1'b1;
        cnt    <= '0;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      dac_code <= '0;
      pwr_dn   <= 1'b1;
      term_sel <= '1;
    end else if (take) begin
      if (cmd == '0 && !pwr_dn)
        dac_code <= data;
      else if (cmd == '1) begin
        pwr_dn   <= (sel != '0);
        term_sel <= sel;
      end
    end

  // R6
  code_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dac_code) |-> $past(!pwr_dn));

  // R11
  update_point_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({dac_code, pwr_dn, term_sel}) |-> $past(active && sck_fall && cnt == LAST));

  // R8
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULL);

  // R7
  cs_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_high |=> !active);

  // R5
  term_when_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_dn |-> term_sel != '0);
endmodule

// File: tb/tb_dac_cmd_slave.sv
module tb_dac_cmd_slave;
  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic [9:0] dac_code;
  logic       pwr_dn;
  logic [1:0] term_sel;

  dac_cmd_slave dut (.clk, .rst_n, .cs_n, .sclk, .sdi, .dac_code, .pwr_dn, .term_sel);

  always #2 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [9:0] m_code = '0;
  logic       m_pd = 1'b1;
  logic [1:0] m_term = 2'b11;

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic apply(input logic [15:0] w);
    if (w[15:12] == 4'h0 && !m_pd) m_code = w[11:2];
    else if (w[15:12] == 4'hF) begin
      m_pd = (w[1:0] != 2'b00);
      m_term = w[1:0];
    end
  endtask

  task automatic check(input string req);
    n_cmp++;
    if (dac_code !== m_code) begin
      n_bad++;
      $display("FAIL %s dac_code=%h expected %h", req, dac_code, m_code);
    end
    n_cmp++;
    if (pwr_dn !== m_pd) begin
      n_bad++;
      $display("FAIL %s pwr_dn=%b expected %b", req, pwr_dn, m_pd);
    end
    n_cmp++;
    if (term_sel !== m_term) begin
      n_bad++;
      $display("FAIL %s term_sel=%b expected %b", req, term_sel, m_term);
    end
  endtask

  task automatic frame(input logic [15:0] w, input int nb, input bit idle_hi,
                       input bit cs_last, input bit keep_low);
    sclk = idle_hi;
    wait_clk(2);
    cs_n = 1'b0;
    wait_clk(4);
    for (int i = 0; i < nb; i++) begin
      sdi = (i < 16) ? w[15-i] : i[0];
      if (!idle_hi) begin
        sclk = 1'b1;
        wait_clk(4);
        sclk = 1'b0;
        if (cs_last && i == nb - 1) cs_n = 1'b1;
        wait_clk(4);
      end else begin
        wait_clk(4);
        sclk = 1'b0;
        if (cs_last && i == nb - 1) cs_n = 1'b1;
        wait_clk(4);
        sclk = 1'b1;
      end
    end
    wait_clk(6);
    if (!keep_low) cs_n = 1'b1;
    wait_clk(6);
  endtask

  task automatic send(input logic [15:0] w, input bit idle_hi, input string req);
    frame(w, 16, idle_hi, 1'b0, 1'b0);
    apply(w);
    check(req);
  endtask

  initial begin
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(3);
    check("R1");

    send({4'h0, 10'h155, 2'b00}, 1'b0, "R6");
    send({4'hF, 10'h000, 2'b00}, 1'b0, "R4");

    // R3 R2 R10: code sweep alternating idle level
    for (int c = 0; c < 1024; c += 7)
      send({4'h0, c[9:0], c[1:0]}, c[0], "R3");
    send({4'h0, 10'h3FF, 2'b10}, 1'b1, "R3");

    // R5 R6 R4: each power-down mode, ignored update, restoring wake
    for (int s = 1; s < 4; s++) begin
      send({4'hF, 10'h2AA, s[1:0]}, s[0], "R5");
      send({4'h0, 10'h0F0, 2'b00}, 1'b0, "R6");
      send({4'hF, 10'h3FF, 2'b00}, 1'b1, "R4");
    end

    // R9: every command nibble in both power states
    for (int p = 0; p < 2; p++)
      for (int k = 0; k < 16; k++) begin
        send({4'hF, 10'h000, p[0], p[0]}, 1'b0, "R5");
        send({k[3:0], 10'(k * 37 + 5), 2'b01}, k[0], "R9");
      end
    send({4'hF, 10'h000, 2'b00}, 1'b0, "R4");

    // R7: truncated frames of every short length
    for (int n = 1; n < 16; n++) begin
      frame({4'h0, 10'(n * 61), 2'b00}, n, n[0], 1'b0, 1'b0);
      check("R7");
    end

    // R8: result before select rises, extra edges ignored
    frame({4'h0, 10'h1C3, 2'b00}, 16, 1'b0, 1'b0, 1'b1);
    apply({4'h0, 10'h1C3, 2'b00});
    check("R8");
    frame(16'h0000, 6, 1'b0, 1'b0, 1'b0);
    check("R8");

    // R7 R8: select rise coincident with the last edge
    frame({4'h0, 10'h2D4, 2'b00}, 16, 1'b0, 1'b1, 1'b0);
    apply({4'h0, 10'h2D4, 2'b00});
    check("R8");
    frame({4'h0, 10'h04B, 2'b00}, 15, 1'b1, 1'b1, 1'b0);
    check("R7");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule